// File: doc/BRIEF.md
# I2C Controller Interrupt and Control Status

This block sits beside the bit-level engine of an I2C bus controller. It turns the engine's event strobes into latched interrupt status. The strobes are arbitration loss, end of a byte with the sampled acknowledge level, and six auxiliary sources. The block masks the status with an enable register and drives a single registered interrupt line. It also owns the two control bits that the engine reads: the master-mode request and the acknowledge level the controller drives when it is the receiver. Hardware events can change the master-mode bit.

Status bit 1 is shared by four roles. When the controller transmits, as master or as slave, the bit reports a not-acknowledge from the far end. When it receives, the bit reports a byte it answered with its acknowledge-level bit high. A master transmitter that sees a not-acknowledge drops its master-mode bit and asks the engine for a stop condition. Software clears a status bit by writing 1 to it, which toggles the bit.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: After synchronous reset, status, enable, master-mode, acknowledge-level, irq and stop_req are all 0.
- R2: A pulse on ev_arb_lost sets status bit 0 at the next clock edge.
- R3: A register write to address 0 (status) inverts each status bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged.
- R4: In master transmit (role_master=1, role_tx=1), ev_byte_done with ev_nack=1 sets status bit 1 and clears master-mode at the same edge. If master-mode was 1, stop_req is high for exactly the one following cycle.
- R5: In master receive (role_master=1, role_tx=0), ev_byte_done sets status bit 1 exactly when the acknowledge-level bit is 1. ev_nack has no effect.
- R6: In slave transmit (role_master=0, role_tx=1), ev_byte_done sets status bit 1 exactly when ev_nack=1.
- R7: In slave receive (both role inputs 0), ev_byte_done sets status bit 1 exactly when the acknowledge-level bit is 1. In every role other than master transmit, a byte event leaves master-mode unchanged.
- R8: Auxiliary strobe ev_aux[k] sets status bit k+2.
- R9: When a hardware event and a software toggle hit the same status bit at the same edge, the bit ends at 1.
- R10: irq is registered. It equals the OR over all bits of (status AND enable) as it stood one cycle earlier.
- R11: Writing master-mode to 0 after an arbitration loss does not set status bit 0 again. A later toggle of bit 0 leaves it at 0.
- R12: The register map is: address 0 is status (toggle on write), address 1 is enable (plain write), address 2 is control with bit 0 master-mode and bit 1 acknowledge-level, and address 3 reads 0 and ignores writes. reg_rdata shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_master | input | 1 | Engine reports master role |
| role_tx | input | 1 | Engine reports transmitter role |
| ev_arb_lost | input | 1 | Arbitration lost strobe |
| ev_byte_done | input | 1 | Byte and acknowledge slot finished |
| ev_nack | input | 1 | Acknowledge slot sampled high, qualifies ev_byte_done |
| ev_aux | input | 6 | Auxiliary interrupt strobes for status bits 2..7 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of addressed register |
| irq | output | 1 | Combined interrupt, registered |
| msms | output | 1 | Master-mode request to the engine |
| txak | output | 1 | Acknowledge level driven when receiving |
| stop_req | output | 1 | One-cycle stop request to the engine |

## Verification
The cycle-by-cycle properties cover several rules: arbitration loss setting bit 0, toggle writes inverting bit 0, the role-dependent setting of bit 1, the drop of master-mode with a single-cycle stop pulse, the fact that only a toggle or an arbitration loss raises bit 0, and the one-cycle lag of irq behind the masked status. The bench scenarios are needed for the rest. They check the full role-by-acknowledge matrix against read-back values, the arbitration recovery order, the collision of a hardware set with a toggle, the per-bit mapping of the auxiliary strobes, and the inert fourth address.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
    localparam int NUM_IRQ  = 8;
    localparam int ADDR_W   = 2;
    localparam int IDX_ARB  = 0;
    localparam int IDX_XFER = 1;
    localparam int CTL_MSMS = 0;
    localparam int CTL_TXAK = 1;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_STATUS  = 2'd0,
        ADDR_ENABLE  = 2'd1,
        ADDR_CONTROL = 2'd2,
        ADDR_SPARE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic is_master;
        logic is_tx;
    } role_t;

    // Bit 1 condition: a transmitter reports the far end's not-acknowledge,
    // a receiver reports its own high acknowledge level.
    function automatic logic xfer_flag(role_t r, logic nack, logic ack_level);
        return r.is_tx ? nack : ack_level;
    endfunction

    function automatic logic drops_master(role_t r, logic nack);
        return r.is_master & r.is_tx & nack;
    endfunction
endpackage

// File: rtl/i2c_irq_decode.sv
module i2c_irq_decode
    import i2c_irq_pkg::*;
#(
    parameter int N_IRQ = NUM_IRQ
) (
    input  role_t            role,
    input  logic             arb_lost,
    input  logic             byte_done,
    input  logic             nack,
    input  logic [N_IRQ-3:0] aux,
    input  logic             ack_level,
    output logic [N_IRQ-1:0] hw_set,
    output logic             drop_msms
);
    localparam int AUX_W = N_IRQ - 2;

    always_comb begin
        hw_set                 = '0;
        hw_set[IDX_ARB]        = arb_lost;
        hw_set[IDX_XFER]       = byte_done & xfer_flag(role, nack, ack_level);
        hw_set[N_IRQ-1:2]      = aux[AUX_W-1:0];
        drop_msms              = byte_done & drops_master(role, nack);
    end
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
    import i2c_irq_pkg::*;
#(
    parameter int N_IRQ = NUM_IRQ
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] hw_set,
    input  logic [N_IRQ-1:0] sw_toggle,
    output logic [N_IRQ-1:0] status_q
);
    for (genvar i = 0; i < N_IRQ; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                status_q[i] <= 1'b0;
            end else if (hw_set[i]) begin
                status_q[i] <= 1'b1;
            end else if (sw_toggle[i]) begin
                status_q[i] <= ~status_q[i];
            end
        end
    end
endmodule

// File: rtl/i2c_irq_ctrl_regs.sv
module i2c_irq_ctrl_regs
    import i2c_irq_pkg::*;
#(
    parameter int N_IRQ = NUM_IRQ
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_enable,
    input  logic             wr_control,
    input  logic [N_IRQ-1:0] wdata,
    input  logic             drop_msms,
    input  logic [N_IRQ-1:0] status_q,
    output logic [N_IRQ-1:0] enable_q,
    output logic             msms_q,
    output logic             txak_q,
    output logic             stop_q,
    output logic             irq_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            msms_q   <= 1'b0;
            txak_q   <= 1'b0;
            stop_q   <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            if (wr_enable) begin
                enable_q <= wdata;
            end
            if (drop_msms) begin
                msms_q <= 1'b0;
            end else if (wr_control) begin
                msms_q <= wdata[CTL_MSMS];
            end
            if (wr_control) begin
                txak_q <= wdata[CTL_TXAK];
            end
            stop_q <= drop_msms & msms_q;
            irq_q  <= |(status_q & enable_q);
        end
    end
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
    import i2c_irq_pkg::*;
#(
    parameter int N_IRQ = NUM_IRQ
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              role_master,
    input  logic              role_tx,
    input  logic              ev_arb_lost,
    input  logic              ev_byte_done,
    input  logic              ev_nack,
    input  logic [N_IRQ-3:0]  ev_aux,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [N_IRQ-1:0]  reg_wdata,
    output logic [N_IRQ-1:0]  reg_rdata,
    output logic              irq,
    output logic              msms,
    output logic              txak,
    output logic              stop_req
);
    role_t            role;
    reg_addr_e        addr;
    logic [N_IRQ-1:0] hw_set;
    logic [N_IRQ-1:0] sw_toggle;
    logic [N_IRQ-1:0] status_q;
    logic [N_IRQ-1:0] enable_q;
    logic             drop_msms;
    logic             wr_enable;
    logic             wr_control;

    always_comb begin
        role.is_master = role_master;
        role.is_tx     = role_tx;
        addr           = reg_addr_e'(reg_addr);
        sw_toggle      = (reg_wr && addr == ADDR_STATUS) ? reg_wdata : '0;
        wr_enable      = reg_wr && addr == ADDR_ENABLE;
        wr_control     = reg_wr && addr == ADDR_CONTROL;
    end

    i2c_irq_decode #(.N_IRQ(N_IRQ)) u_decode (
        .role      (role),
        .arb_lost  (ev_arb_lost),
        .byte_done (ev_byte_done),
        .nack      (ev_nack),
        .aux       (ev_aux),
        .ack_level (txak),
        .hw_set    (hw_set),
        .drop_msms (drop_msms)
    );

    i2c_irq_status #(.N_IRQ(N_IRQ)) u_status (
        .clk       (clk),
        .rst       (rst),
        .hw_set    (hw_set),
        .sw_toggle (sw_toggle),
        .status_q  (status_q)
    );

    i2c_irq_ctrl_regs #(.N_IRQ(N_IRQ)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_enable  (wr_enable),
        .wr_control (wr_control),
        .wdata      (reg_wdata),
        .drop_msms  (drop_msms),
        .status_q   (status_q),
        .enable_q   (enable_q),
        .msms_q     (msms),
        .txak_q     (txak),
        .stop_q     (stop_req),
        .irq_q      (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (addr)
            ADDR_STATUS:  reg_rdata = status_q;
            ADDR_ENABLE:  reg_rdata = enable_q;
            ADDR_CONTROL: begin
                reg_rdata[CTL_MSMS] = msms;
                reg_rdata[CTL_TXAK] = txak;
            end
            default:      reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2c_irq_ctrl_chk.sv
module i2c_irq_ctrl_chk #(
    parameter int N_IRQ = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             role_master,
    input logic             role_tx,
    input logic             ev_arb_lost,
    input logic             ev_byte_done,
    input logic             ev_nack,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [N_IRQ-1:0] reg_wdata,
    input logic [N_IRQ-1:0] status_q,
    input logic [N_IRQ-1:0] enable_q,
    input logic             msms,
    input logic             txak,
    input logic             irq,
    input logic             stop_req
);
    logic mt_nack;
    logic toggle0;
    logic ctl_wr;
    assign mt_nack = ev_byte_done && ev_nack && role_master && role_tx;
    assign toggle0 = reg_wr && reg_addr == 2'd0 && reg_wdata[0];
    assign ctl_wr  = reg_wr && reg_addr == 2'd2;

    p_arb_sets_r2: assert property (@(posedge clk) disable iff (rst)
        ev_arb_lost |=> status_q[0]);

    p_toggle_flips_r3: assert property (@(posedge clk) disable iff (rst)
        toggle0 && !ev_arb_lost |=> status_q[0] != $past(status_q[0]));

    p_mt_nack_drop_r4: assert property (@(posedge clk) disable iff (rst)
        mt_nack |=> !msms && status_q[1]);

    p_stop_single_r4: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> !stop_req);

    p_rx_ack_level_r5: assert property (@(posedge clk) disable iff (rst)
        ev_byte_done && !role_tx && txak |=> status_q[1]);

    p_tx_nack_r6: assert property (@(posedge clk) disable iff (rst)
        ev_byte_done && role_tx && ev_nack |=> status_q[1]);

    p_msms_hold_r7: assert property (@(posedge clk) disable iff (rst)
        msms && !mt_nack && !ctl_wr |=> msms);

    p_irq_rise_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|(status_q & enable_q)));

    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !(|(status_q & enable_q)) |=> !irq);

    p_arb_no_reset_r11: assert property (@(posedge clk) disable iff (rst)
        !status_q[0] && !ev_arb_lost && !toggle0 |=> !status_q[0]);
endmodule

bind i2c_irq_ctrl i2c_irq_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .role_master  (role_master),
    .role_tx      (role_tx),
    .ev_arb_lost  (ev_arb_lost),
    .ev_byte_done (ev_byte_done),
    .ev_nack      (ev_nack),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .status_q     (status_q),
    .enable_q     (enable_q),
    .msms         (msms),
    .txak         (txak),
    .irq          (irq),
    .stop_req     (stop_req)
);

// File: tb/tb_i2c_irq_ctrl.sv
module tb_i2c_irq_ctrl;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         role_master = 1'b0, role_tx = 1'b0;
    logic         ev_arb_lost = 1'b0, ev_byte_done = 1'b0, ev_nack = 1'b0;
    logic [N-3:0] ev_aux = '0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         irq, msms, txak, stop_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_irq_ctrl dut (
        .clk(clk), .rst(rst), .role_master(role_master), .role_tx(role_tx),
        .ev_arb_lost(ev_arb_lost), .ev_byte_done(ev_byte_done), .ev_nack(ev_nack),
        .ev_aux(ev_aux), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .msms(msms), .txak(txak), .stop_req(stop_req)
    );

    // {master, tx, ack_level, nack, expected bit1, expected master-mode}
    localparam logic [5:0] VEC [10] = '{
        6'b110110, 6'b110001, 6'b111001, 6'b101011, 6'b100001,
        6'b100101, 6'b010111, 6'b010001, 6'b001011, 6'b000101
    };

    task automatic chk(input string tag, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic clear_status();
        logic [N-1:0] s;
        rd(2'd0, s);
        if (s != '0) wr(2'd0, s);
    endtask

    function automatic string role_tag(input logic m, input logic t);
        if (m && t) return "R4";
        if (m)      return "R5";
        if (t)      return "R6";
        return "R7";
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [N-1:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1", "status", v, '0);
        rd(2'd1, v); chk("R1", "enable", v, '0);
        rd(2'd2, v); chk("R1", "control", v, '0);
        chk("R1", "irq/msms/txak/stop", {irq, msms, txak, stop_req}, '0);

        // Role matrix for status bit 1 (R4 R5 R6 R7)
        for (int i = 0; i < 10; i++) begin
            logic [5:0] e;
            e = VEC[i];
            wr(2'd2, {6'b0, e[3], 1'b1});
            role_master = e[5]; role_tx = e[4];
            ev_byte_done = 1'b1; ev_nack = e[2];
            @(negedge clk);
            ev_byte_done = 1'b0; ev_nack = 1'b0;
            rd(2'd0, v);
            chk(role_tag(e[5], e[4]), $sformatf("vec%0d bit1", i), {7'b0, v[1]}, {7'b0, e[1]});
            chk(role_tag(e[5], e[4]), $sformatf("vec%0d msms", i), {7'b0, msms}, {7'b0, e[0]});
            clear_status();
        end

        // R4 stop pulse
        wr(2'd2, 8'h01);
        role_master = 1'b1; role_tx = 1'b1;
        ev_byte_done = 1'b1; ev_nack = 1'b1;
        @(negedge clk);
        ev_byte_done = 1'b0; ev_nack = 1'b0;
        chk("R4", "stop first", {7'b0, stop_req}, 8'h01);
        @(negedge clk);
        chk("R4", "stop second", {7'b0, stop_req}, 8'h00);
        ev_byte_done = 1'b1; ev_nack = 1'b1;
        @(negedge clk);
        ev_byte_done = 1'b0; ev_nack = 1'b0;
        chk("R4", "no stop when idle", {7'b0, stop_req}, 8'h00);
        clear_status();

        // R2 / R11 arbitration loss and recovery order
        wr(2'd2, 8'h01);
        ev_arb_lost = 1'b1;
        @(negedge clk);
        ev_arb_lost = 1'b0;
        rd(2'd0, v); chk("R2", "arb bit0", v, 8'h01);
        wr(2'd2, 8'h00);
        rd(2'd0, v); chk("R11", "bit0 after msms clear", v, 8'h01);
        chk("R11", "msms cleared", {7'b0, msms}, 8'h00);
        wr(2'd0, 8'h01);
        @(negedge clk);
        rd(2'd0, v); chk("R11", "bit0 after toggle", v, 8'h00);

        // R3 toggle semantics
        wr(2'd0, 8'h30);
        rd(2'd0, v); chk("R3", "toggle sets", v, 8'h30);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R3", "zero write keeps", v, 8'h30);
        wr(2'd0, 8'h10);
        rd(2'd0, v); chk("R3", "toggle clears one", v, 8'h20);
        clear_status();

        // R8 auxiliary mapping
        for (int k = 0; k < N - 2; k++) begin
            ev_aux = '0; ev_aux[k] = 1'b1;
            @(negedge clk);
            ev_aux = '0;
            rd(2'd0, v);
            chk("R8", $sformatf("aux%0d", k), v, 8'(1 << (k + 2)));
            clear_status();
        end

        // R9 hardware set beats toggle
        ev_aux[1] = 1'b1;
        wr(2'd0, 8'h08);
        ev_aux = '0;
        rd(2'd0, v); chk("R9", "collide from 0", v, 8'h08);
        ev_aux[1] = 1'b1;
        wr(2'd0, 8'h08);
        ev_aux = '0;
        rd(2'd0, v); chk("R9", "collide from 1", v, 8'h08);
        clear_status();

        // R10 registered masked interrupt
        ev_aux[0] = 1'b1;
        @(negedge clk);
        ev_aux = '0;
        @(negedge clk);
        chk("R10", "masked", {7'b0, irq}, 8'h00);
        wr(2'd1, 8'h04);
        chk("R10", "one cycle lag", {7'b0, irq}, 8'h00);
        @(negedge clk);
        chk("R10", "asserted", {7'b0, irq}, 8'h01);
        wr(2'd0, 8'h04);
        chk("R10", "still high", {7'b0, irq}, 8'h01);
        @(negedge clk);
        chk("R10", "deasserted", {7'b0, irq}, 8'h00);

        // R12 register map
        wr(2'd1, 8'hA5);
        rd(2'd1, v); chk("R12", "enable readback", v, 8'hA5);
        wr(2'd3, 8'hFF);
        rd(2'd3, v); chk("R12", "spare reads 0", v, 8'h00);
        rd(2'd1, v); chk("R12", "enable untouched", v, 8'hA5);
        rd(2'd0, v); chk("R12", "status untouched", v, 8'h00);
        wr(2'd2, 8'h02);
        rd(2'd2, v); chk("R12", "control fields", v, 8'h02);
        wr(2'd1, 8'h00);

        summary();
    end
endmodule